// File: doc/BRIEF.md
# Semi-Period Measurement Counter

This block measures how long a digital gate signal stays high and how long it stays low, in units of timebase ticks. A tick strobe, one clock wide, marks each tick. An interval counter advances by one on every tick, whatever level the gate has. Each time the gate changes level, in either direction, the counter's value is handed to an output stream and the counter starts a new interval. Gate changes are detected after a clock-domain synchronizer. A tick that arrives in the same cycle as a detected change is never lost: it becomes the first count of the new interval.

Software or a sequencer pulses the arm input to start a measurement. A polarity select, taken at arm time, chooses whether the first reported interval must end on a rising or on a falling gate change. Changes of the other direction that come before that first qualifying change are ignored. The first word after arming covers the time from arming to that first change. It is delivered but flagged as a startup sample. After it, the words alternate between high-time and low-time intervals, each with a level tag. The stream uses a valid/ready handshake with a single holding register. A word that cannot be stored is dropped and flagged with a sticky overrun bit. A counter that reaches its maximum value saturates and raises a sticky overflow bit. Arming again clears both flags.

Top module: `semiperiod_meter`

## Requirements
- R1: Reset is synchronous and active high. After reset the block is idle: out_valid_o, overflow_o and overrun_o are 0. Until arm_i is seen, no tick is counted and no gate change produces a word.
- R2: A cycle with arm_i high clears the interval counter, overflow_o and overrun_o, and starts waiting for the first qualifying gate change. The output holding register is left as it is.
- R3: While armed, the interval counter rises by exactly one in every cycle where tick_i is high, whether the gate is high or low.
- R4: gate_i passes through SYNC_STAGES flip-flops (default 2). With the default, a gate level first sampled at clock edge n is acted on at edge n+2. Ticks sampled up to edge n+1 belong to the interval that ends. The tick sampled at edge n+2 belongs to the interval that starts.
- R5: At a capture, the word holds the count before that cycle's tick. The counter restarts at 1 when tick_i is high in the capture cycle and at 0 otherwise.
- R6: first_rise_i is sampled at arm. A value of 1 means the first word must end on a rising gate change, and 0 means it must end on a falling one. Changes of the opposite direction before that first word cause neither a word nor a counter restart.
- R7: After the first word, every gate change, rising or falling, produces a word. out_level_o is 1 for an interval that ends on a falling change (high time) and 0 for one that ends on a rising change (low time).
- R8: out_startup_o is 1 on the first word after each arm and 0 on every later word.
- R9: A word is transferred when out_valid_o and out_ready_i are both high. While out_valid_o is high and out_ready_i is low, out_valid_o stays high and out_count_o, out_level_o and out_startup_o stay unchanged.
- R10: A capture that occurs while the holding register keeps an unaccepted word (out_valid_o high, out_ready_i low) drops the new word and sets overrun_o. overrun_o stays set until the next arm. A capture in a cycle where the held word is accepted loads the new word.
- R11: The interval counter saturates at 2^CNT_W-1. A tick while it is at that value leaves it there and sets overflow_o, which stays set until the next arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Timebase tick strobe, one count per high cycle |
| gate_i | input | 1 | Asynchronous gate signal being measured |
| arm_i | input | 1 | Start or restart a measurement |
| first_rise_i | input | 1 | 1: first word ends on a rising change; 0: on a falling one |
| out_ready_i | input | 1 | Downstream accepts the offered word |
| out_valid_o | output | 1 | A captured word is offered |
| out_count_o | output | CNT_W | Ticks counted in the interval |
| out_level_o | output | 1 | 1: high-time interval; 0: low-time interval |
| out_startup_o | output | 1 | Word covers the time from arming to the first change |
| overflow_o | output | 1 | Sticky: the counter saturated since the last arm |
| overrun_o | output | 1 | Sticky: a word was dropped since the last arm |

## Verification
The bound checker checks on every cycle the properties that follow from one or two register updates. These are the one-step advance of the counter, its restart at 0 or 1 after a capture, its saturation, the clearing done by arm, the stable holding of an unaccepted word, the loading of an accepted one and the overrun on a dropped one. The complete sequences of words can only be shown by the bench's scenarios. These cover the synchronizer latency, the choice of polarity and the edges ignored before the first capture, the alternating level tags, the startup flag, and interval values under both continuous and sparse ticks.

// File: rtl/spm_pkg.sv
package spm_pkg;

  // Measurement phase of the capture controller
  typedef enum logic [1:0] {
    SPM_IDLE  = 2'd0,   // not armed, counter held at zero
    SPM_WAIT  = 2'd1,   // armed, waiting for the first qualifying change
    SPM_RUN   = 2'd2    // every change produces a word
  } spm_phase_e;

endpackage

// File: rtl/spm_gate_sync.sv
module spm_gate_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic gate_i,
  output logic prev_o,   // synchronized level one cycle back
  output logic rise_o,
  output logic fall_o
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  // Synchronizer chain, one flop per stage
  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[gi] <= 1'b0;
          else     chain_q[gi] <= gate_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[gi] <= 1'b0;
          else     chain_q[gi] <= chain_q[gi-1];
        end
      end
    end
  endgenerate

  // History flop for change detection
  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain_q[LAST];
  end

  assign prev_o = prev_q;
  assign rise_o = chain_q[LAST] & ~prev_q;
  assign fall_o = ~chain_q[LAST] & prev_q;

endmodule

// File: rtl/spm_tick_counter.sv
module spm_tick_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear_i,    // arm: force zero
  input  logic         enable_i,   // armed
  input  logic         restart_i,  // capture: start new interval
  input  logic         tick_i,
  output logic [W-1:0] value_o,
  output logic         sat_o       // tick arrived while at maximum
);

  localparam logic [W-1:0] MAX_VAL = {W{1'b1}};
  localparam logic [W-1:0] ONE     = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] value_q;
  logic         at_max;

  assign at_max = (value_q == MAX_VAL);

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      value_q <= '0;
    end else if (enable_i) begin
      if (restart_i) begin
        // the coinciding tick opens the new interval
        value_q <= tick_i ? ONE : '0;
      end else if (tick_i && !at_max) begin
        value_q <= value_q + ONE;
      end
    end
  end

  assign value_o = value_q;
  assign sat_o   = enable_i & ~clear_i & ~restart_i & tick_i & at_max;

endmodule

// File: rtl/spm_capture_ctrl.sv
module spm_capture_ctrl
  import spm_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic arm_i,
  input  logic first_rise_i,
  input  logic rise_i,
  input  logic fall_i,
  input  logic prev_level_i,
  output logic active_o,
  output logic capture_o,
  output logic cap_level_o,
  output logic cap_startup_o
);

  spm_phase_e phase_q, phase_d;
  logic       first_rise_q;
  logic       qualifying;
  logic       any_change;

  assign qualifying = first_rise_q ? rise_i : fall_i;
  assign any_change = rise_i | fall_i;

  always_comb begin
    capture_o = 1'b0;
    phase_d   = phase_q;
    if (arm_i) begin
      phase_d = SPM_WAIT;
    end else begin
      unique case (phase_q)
        SPM_WAIT: begin
          if (qualifying) begin
            capture_o = 1'b1;
            phase_d   = SPM_RUN;
          end
        end
        SPM_RUN:  capture_o = any_change;
        default:  capture_o = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q      <= SPM_IDLE;
      first_rise_q <= 1'b1;
    end else begin
      phase_q <= phase_d;
      if (arm_i) first_rise_q <= first_rise_i;
    end
  end

  assign active_o      = (phase_q != SPM_IDLE);
  // the interval ending now had the level held before the change
  assign cap_level_o   = prev_level_i;
  assign cap_startup_o = (phase_q == SPM_WAIT);

endmodule

// File: rtl/spm_out_stage.sv
module spm_out_stage #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] count_i,
  input  logic         level_i,
  input  logic         startup_i,
  input  logic         ready_i,
  output logic         valid_o,
  output logic [W-1:0] count_o,
  output logic         level_o,
  output logic         startup_o,
  output logic         drop_o
);

  logic         valid_q;
  logic [W-1:0] count_q;
  logic         level_q;
  logic         startup_q;
  logic         blocked;

  assign blocked = valid_q & ~ready_i;
  assign drop_o  = load_i & blocked;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q   <= 1'b0;
      count_q   <= '0;
      level_q   <= 1'b0;
      startup_q <= 1'b0;
    end else if (load_i && !blocked) begin
      valid_q   <= 1'b1;
      count_q   <= count_i;
      level_q   <= level_i;
      startup_q <= startup_i;
    end else if (ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o   = valid_q;
  assign count_o   = count_q;
  assign level_o   = level_q;
  assign startup_o = startup_q;

endmodule

// File: rtl/semiperiod_meter.sv
module semiperiod_meter #(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             gate_i,
  input  logic             arm_i,
  input  logic             first_rise_i,
  input  logic             out_ready_i,
  output logic             out_valid_o,
  output logic [CNT_W-1:0] out_count_o,
  output logic             out_level_o,
  output logic             out_startup_o,
  output logic             overflow_o,
  output logic             overrun_o
);

  logic             g_prev, g_rise, g_fall;
  logic             active, cap_fire, cap_level, cap_startup;
  logic [CNT_W-1:0] cnt_value;
  logic             cnt_sat;
  logic             word_drop;
  logic             overflow_q, overrun_q;

  spm_gate_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .gate_i (gate_i),
    .prev_o (g_prev),
    .rise_o (g_rise),
    .fall_o (g_fall)
  );

  spm_capture_ctrl u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .arm_i         (arm_i),
    .first_rise_i  (first_rise_i),
    .rise_i        (g_rise),
    .fall_i        (g_fall),
    .prev_level_i  (g_prev),
    .active_o      (active),
    .capture_o     (cap_fire),
    .cap_level_o   (cap_level),
    .cap_startup_o (cap_startup)
  );

  spm_tick_counter #(.W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .clear_i   (arm_i),
    .enable_i  (active),
    .restart_i (cap_fire),
    .tick_i    (tick_i),
    .value_o   (cnt_value),
    .sat_o     (cnt_sat)
  );

  spm_out_stage #(.W(CNT_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .load_i    (cap_fire),
    .count_i   (cnt_value),
    .level_i   (cap_level),
    .startup_i (cap_startup),
    .ready_i   (out_ready_i),
    .valid_o   (out_valid_o),
    .count_o   (out_count_o),
    .level_o   (out_level_o),
    .startup_o (out_startup_o),
    .drop_o    (word_drop)
  );

  // Sticky status, cleared by arm
  always_ff @(posedge clk) begin
    if (rst || arm_i) begin
      overflow_q <= 1'b0;
      overrun_q  <= 1'b0;
    end else begin
      if (cnt_sat)   overflow_q <= 1'b1;
      if (word_drop) overrun_q  <= 1'b1;
    end
  end

  assign overflow_o = overflow_q;
  assign overrun_o  = overrun_q;

endmodule

// File: rtl/spm_checker.sv
module spm_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         arm,
  input logic         tick,
  input logic         active,
  input logic         capture,
  input logic [W-1:0] count,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_count,
  input logic         out_level,
  input logic         out_startup,
  input logic         overflow,
  input logic         overrun
);

  localparam logic [W-1:0] MAX_VAL = {W{1'b1}};
  localparam logic [W-1:0] ONE     = {{(W-1){1'b0}}, 1'b1};

  assert_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !active |-> count == '0);

  assert_arm_clears_R2: assert property (@(posedge clk) disable iff (rst)
    arm |=> (count == '0) && !overflow && !overrun);

  assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
    active && !arm && !capture && tick && count != MAX_VAL |=> count == $past(count) + ONE);

  assert_restart_one_R5: assert property (@(posedge clk) disable iff (rst)
    capture && tick |=> count == ONE);

  assert_restart_zero_R5: assert property (@(posedge clk) disable iff (rst)
    capture && !tick |=> count == '0);

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_count) && $stable(out_level) && $stable(out_startup));

  assert_load_R9: assert property (@(posedge clk) disable iff (rst)
    capture && !(out_valid && !out_ready) |=> out_valid && out_count == $past(count));

  assert_overrun_R10: assert property (@(posedge clk) disable iff (rst)
    capture && out_valid && !out_ready |=> overrun);

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (rst)
    active && !arm && !capture && tick && count == MAX_VAL |=> count == MAX_VAL && overflow);

  assert_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    overflow && !arm |=> overflow);

endmodule

bind semiperiod_meter spm_checker #(.W(CNT_W)) u_spm_chk (
  .clk         (clk),
  .rst         (rst),
  .arm         (arm_i),
  .tick        (tick_i),
  .active      (active),
  .capture     (cap_fire),
  .count       (cnt_value),
  .out_valid   (out_valid_o),
  .out_ready   (out_ready_i),
  .out_count   (out_count_o),
  .out_level   (out_level_o),
  .out_startup (out_startup_o),
  .overflow    (overflow_o),
  .overrun     (overrun_o)
);

// File: tb/tb_semiperiod_meter.sv
module tb_semiperiod_meter;

  localparam int PERIOD = 10;
  localparam int TB_W   = 8;

  logic clk = 1'b0;
  logic rst, tick, gate, arm, first_rise, ready;
  logic            out_valid, out_level, out_startup, overflow, overrun;
  logic [TB_W-1:0] out_count;

  int checks = 0;
  int errors = 0;
  int n_got  = 0;
  int base;
  logic [TB_W-1:0] got_cnt [0:63];
  logic            got_lvl [0:63];
  logic            got_st  [0:63];

  always #(PERIOD/2) clk = ~clk;

  semiperiod_meter #(.CNT_W(TB_W), .SYNC_STAGES(2)) dut (
    .clk           (clk),
    .rst           (rst),
    .tick_i        (tick),
    .gate_i        (gate),
    .arm_i         (arm),
    .first_rise_i  (first_rise),
    .out_ready_i   (ready),
    .out_valid_o   (out_valid),
    .out_count_o   (out_count),
    .out_level_o   (out_level),
    .out_startup_o (out_startup),
    .overflow_o    (overflow),
    .overrun_o     (overrun)
  );

  // Record each handshake; it completes at the following rising edge
  always @(negedge clk) begin
    if (!rst && out_valid && ready && n_got < 64) begin
      got_cnt[n_got] = out_count;
      got_lvl[n_got] = out_level;
      got_st[n_got]  = out_startup;
      n_got++;
    end
  end

  initial begin
    #(PERIOD * 50000);
    errors++;
    $display("FAIL watchdog: run did not complete actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic expect_word(input int idx, input int cnt, input logic lvl, input logic st, input string req);
    checks++;
    if (idx >= n_got) begin
      errors++;
      $display("FAIL %s word %0d missing actual=%0d words expected=%0d", req, idx - base, n_got - base, idx - base + 1);
    end else if (got_cnt[idx] != cnt[TB_W-1:0] || got_lvl[idx] != lvl || got_st[idx] != st) begin
      errors++;
      $display("FAIL %s word %0d actual=%0d/%0b/%0b expected=%0d/%0b/%0b", req, idx - base,
               got_cnt[idx], got_lvl[idx], got_st[idx], cnt, lvl, st);
    end
  endtask

  // One clock cycle with the given inputs; returns just after the edge
  task automatic cyc(input logic t, input logic g, input logic a);
    @(negedge clk);
    tick = t; gate = g; arm = a;
    @(posedge clk);
    #1;
  endtask

  task automatic set_ready(input logic v);
    @(posedge clk);
    #1 ready = v;
  endtask

  task automatic t_reset_idle;
    chk("R1", "out_valid after reset", out_valid, 0);
    chk("R1", "overflow after reset", overflow, 0);
    chk("R1", "overrun after reset", overrun, 0);
    repeat (3) cyc(1, 1, 0);
    repeat (3) cyc(1, 0, 0);
    repeat (4) cyc(1, 0, 0);
    chk("R1", "words before arm", n_got, 0);
  endtask

  // R3 R4 R5 R7 R8: continuous ticks, rising first
  task automatic t_continuous;
    first_rise = 1'b1;
    cyc(1, 0, 1);
    base = n_got;
    repeat (3) cyc(1, 0, 0);
    repeat (6) cyc(1, 1, 0);
    repeat (4) cyc(1, 0, 0);
    repeat (5) cyc(1, 1, 0);
    chk("R7", "words in continuous run", n_got - base, 3);
    expect_word(base + 0, 5, 1'b0, 1'b1, "R8");
    expect_word(base + 1, 6, 1'b1, 1'b0, "R5");
    expect_word(base + 2, 4, 1'b0, 1'b0, "R3");
    chk("R11", "no overflow on short intervals", overflow, 0);
  endtask

  // R6: falling change before the first rising one is ignored
  task automatic t_ignore_opposite;
    first_rise = 1'b1;
    repeat (5) cyc(1, 1, 0);
    cyc(1, 1, 1);
    base = n_got;
    repeat (2) cyc(1, 1, 0);
    repeat (5) cyc(1, 0, 0);
    chk("R6", "no word for ignored falling change", n_got - base, 0);
    repeat (3) cyc(1, 1, 0);
    repeat (4) cyc(1, 0, 0);
    chk("R6", "words after first rise", n_got - base, 2);
    expect_word(base + 0, 9, 1'b0, 1'b1, "R6");
    expect_word(base + 1, 3, 1'b1, 1'b0, "R7");
  endtask

  // R6: falling polarity selected
  task automatic t_falling_first;
    first_rise = 1'b0;
    repeat (4) cyc(1, 0, 0);
    cyc(1, 0, 1);
    base = n_got;
    cyc(1, 0, 0);
    repeat (4) cyc(1, 1, 0);
    chk("R6", "rising change ignored with falling polarity", n_got - base, 0);
    repeat (3) cyc(1, 0, 0);
    repeat (4) cyc(1, 1, 0);
    expect_word(base + 0, 7, 1'b1, 1'b1, "R6");
    expect_word(base + 1, 3, 1'b0, 1'b0, "R7");
  endtask

  // R3 R4: sparse ticks kept away from the gate changes
  task automatic t_sparse;
    first_rise = 1'b1;
    repeat (5) cyc(0, 0, 0);
    cyc(0, 0, 1);
    base = n_got;
    repeat (5) begin
      cyc(1, 0, 0);
      cyc(0, 0, 0);
    end
    repeat (2) cyc(0, 0, 0);
    repeat (3) cyc(0, 1, 0);
    repeat (7) cyc(1, 1, 0);
    repeat (2) cyc(0, 1, 0);
    repeat (3) cyc(0, 0, 0);
    repeat (2) cyc(1, 0, 0);
    cyc(0, 0, 0);
    repeat (5) cyc(0, 1, 0);
    expect_word(base + 0, 5, 1'b0, 1'b1, "R3");
    expect_word(base + 1, 7, 1'b1, 1'b0, "R4");
    expect_word(base + 2, 2, 1'b0, 1'b0, "R4");
  endtask

  // R9 R10: held word, dropped capture, sticky overrun
  task automatic t_overrun;
    first_rise = 1'b1;
    repeat (5) cyc(1, 0, 0);
    set_ready(1'b0);
    cyc(1, 0, 1);
    base = n_got;
    cyc(1, 0, 0);
    repeat (3) cyc(1, 1, 0);
    repeat (3) cyc(1, 0, 0);
    repeat (4) cyc(1, 0, 0);
    chk("R9", "word held while not ready", out_valid, 1);
    chk("R9", "held count", out_count, 3);
    chk("R9", "held startup flag", out_startup, 1);
    chk("R10", "overrun after dropped word", overrun, 1);
    set_ready(1'b1);
    cyc(1, 0, 0);
    cyc(1, 0, 0);
    chk("R9", "one word accepted", n_got - base, 1);
    expect_word(base + 0, 3, 1'b0, 1'b1, "R10");
    chk("R10", "overrun stays until arm", overrun, 1);
    cyc(1, 0, 1);
    chk("R2", "arm clears overrun", overrun, 0);
  endtask

  // R11: saturation and sticky overflow
  task automatic t_overflow;
    first_rise = 1'b1;
    repeat (4) cyc(1, 0, 0);
    cyc(1, 0, 1);
    base = n_got;
    repeat (300) cyc(1, 0, 0);
    chk("R11", "overflow after saturation", overflow, 1);
    chk("R11", "no word while gate steady", n_got - base, 0);
    repeat (5) cyc(1, 1, 0);
    expect_word(base + 0, 255, 1'b0, 1'b1, "R11");
    chk("R11", "overflow sticky", overflow, 1);
    cyc(1, 1, 1);
    chk("R2", "arm clears overflow", overflow, 0);
  endtask

  initial begin
    rst = 1'b1; tick = 1'b0; gate = 1'b0; arm = 1'b0;
    first_rise = 1'b1; ready = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset_idle();
    t_continuous();
    t_ignore_opposite();
    t_falling_first();
    t_sparse();
    t_overrun();
    t_overflow();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule